// File: doc/BRIEF.md
# Half-Bridge Gate Drive Sequencer

This block sequences the two gate enables of a synchronous buck half-bridge from a three-level PWM command. Comparators outside the block have already reduced the PWM pin to one of three levels: high, low or mid-level. A high level turns the high side on and a low level turns the low side on. A mid level held long enough parks both switches off. Every change of switch first turns the conducting gate off after a turn-off delay. The opposite gate turns on only after that gate's feedback reports it low for a programmable dead time.

An active-low diode-emulation enable lets a zero-crossing indication release the low side once a blanking window has passed. This avoids reverse inductor current at light load. A supply-good flag gates everything: while it is low, both enables are forced off. After a drop in supply or a tri-state shutdown, the block waits for a fresh valid level before it switches again. All asynchronous inputs pass through two-flop synchronizers. All delays are clock-cycle parameters.

Top module: `hb_gate_seq`

## Requirements
- R1: During reset, and after reset while supply_ok_i is low, hs_on_o and ls_on_o are 0 and state_o is 0 (all-off).
- R2: With pwm_lvl_i = 2'b00 (low) the block settles to ls_on_o=1, hs_on_o=0, state_o=5. With pwm_lvl_i = 2'b01 (high) it settles to hs_on_o=1, ls_on_o=0, state_o=2.
- R3: A gate turns on only after the opposite gate-low feedback input has been 1 for ON_DLY consecutive synchronized cycles. While ls_gate_low_i stays 0, a high command leaves hs_on_o at 0 in state_o=1.
- R4: After a high-to-low command, hs_on_o stays 1 for OFF_DLY cycles in state_o=3. The command reaches the state machine on the third rising edge. With the defaults, hs_on_o is still 1 after four edges and is 0 after five.
- R5: A high level that lasts fewer than MIN_ON_CYC synchronized cycles is ignored. One that lasts MIN_ON_CYC cycles is accepted.
- R6: A mid level (pwm_lvl_i[1]=1, codes 2'b10 and 2'b11) held for TSHO_CYC synchronized cycles forces both enables off with state_o=0. A shorter mid level leaves the gates unchanged.
- R7: After a tri-state shutdown or a return of supply, both enables stay off until a high or low level is seen. Sequencing then resumes from that level.
- R8: With dem_en_ni=1, the low side stays on during a low command whatever zc_i does.
- R9: With dem_en_ni=0, zc_i releases the low side (state_o=7, ls_on_o=0) only after BLANK_CYC cycles in state 5. A zc_i pulse inside that window is ignored.
- R10: After a diode-emulation release, the low side stays off while the command stays low. The next accepted high resumes normal sequencing.
- R11: When supply_ok_i falls, both enables are 0 from the second rising edge after the fall.
- R12: With dem_en_ni=0 and the low side on, a mid level held for the hold-off time turns the low side off even with zc_i=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| pwm_lvl_i | input | 2 | Decoded PWM level: 00 low, 01 high, 1x mid |
| dem_en_ni | input | 1 | Diode-emulation enable, active low |
| zc_i | input | 1 | Inductor current zero-crossing indication |
| hs_gate_low_i | input | 1 | High-side gate below its low threshold |
| ls_gate_low_i | input | 1 | Low-side gate below its low threshold |
| supply_ok_i | input | 1 | Supply above lockout threshold |
| hs_on_o | output | 1 | High-side gate enable |
| ls_on_o | output | 1 | Low-side gate enable |
| state_o | output | 3 | Sequencer state code |

## Verification
The hardest situation to reach is a zero-crossing pulse that falls inside the blanking window. The pulse must arrive after the low side has turned on but before BLANK_CYC cycles have passed, and the two-cycle synchronizer makes that timing tight. The bench polls ls_on_o at each falling edge and raises zc_i in the same cycle the low side is first seen on, so the synchronized pulse lands early in the window. A second hard case is a stuck low-side feedback. The bench derives each gate-low feedback from the opposite output and can pin the low-side feedback to 0, which holds the sequencer in its dead-time wait.

// File: rtl/hb_gate_pkg.sv
package hb_gate_pkg;
  typedef enum logic [2:0] {
    ST_OFF     = 3'd0,
    ST_HS_DT   = 3'd1,
    ST_HS_ON   = 3'd2,
    ST_HS_TOFF = 3'd3,
    ST_LS_DT   = 3'd4,
    ST_LS_ON   = 3'd5,
    ST_LS_TOFF = 3'd6,
    ST_LS_REL  = 3'd7
  } hb_state_e;
endpackage

// File: rtl/hb_sync.sv
module hb_sync #(
  parameter int unsigned W = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q, sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= RST_VAL;
      sync_q <= RST_VAL;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/hb_lvl_qual.sv
module hb_lvl_qual #(
  parameter int unsigned MIN_ON_CYC = 2,
  parameter int unsigned TSHO_CYC   = 8
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] lvl_i,
  output logic       hi_q_o,
  output logic       lo_q_o,
  output logic       tri_trip_o
);
  localparam int unsigned HW = $clog2(MIN_ON_CYC + 1);
  localparam int unsigned TW = $clog2(TSHO_CYC + 1);
  localparam logic [HW-1:0] HI_MAX = HW'(MIN_ON_CYC);
  localparam logic [HW-1:0] HI_LIM = HW'(MIN_ON_CYC - 1);
  localparam logic [TW-1:0] TR_MAX = TW'(TSHO_CYC);
  localparam logic [TW-1:0] TR_LIM = TW'(TSHO_CYC - 1);

  logic          is_hi, is_mid;
  logic [HW-1:0] hi_run;
  logic [TW-1:0] tri_run;

  assign is_hi  = (lvl_i == 2'b01);
  assign is_mid = lvl_i[1];

  // saturating run-length counters of consecutive levels
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_run  <= '0;
      tri_run <= '0;
    end else begin
      if (!is_hi)             hi_run <= '0;
      else if (hi_run != HI_MAX) hi_run <= hi_run + 1'b1;
      if (!is_mid)            tri_run <= '0;
      else if (tri_run != TR_MAX) tri_run <= tri_run + 1'b1;
    end
  end

  assign hi_q_o     = is_hi && (hi_run >= HI_LIM);
  assign lo_q_o     = (lvl_i == 2'b00);
  assign tri_trip_o = is_mid && (tri_run >= TR_LIM);
endmodule

// File: rtl/hb_fsm.sv
module hb_fsm
  import hb_gate_pkg::*;
#(
  parameter int unsigned OFF_DLY   = 2,
  parameter int unsigned ON_DLY    = 1,
  parameter int unsigned BLANK_CYC = 8
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      hi_q_i,
  input  logic      lo_q_i,
  input  logic      tri_trip_i,
  input  logic      sup_ok_i,
  input  logic      dem_on_i,
  input  logic      zc_i,
  input  logic      hs_fb_low_i,
  input  logic      ls_fb_low_i,
  output hb_state_e st_o,
  output logic      hs_on_o,
  output logic      ls_on_o
);
  localparam int unsigned M1   = (OFF_DLY > ON_DLY) ? OFF_DLY : ON_DLY;
  localparam int unsigned CMAX = (M1 > BLANK_CYC) ? M1 : BLANK_CYC;
  localparam int unsigned CW   = $clog2(CMAX + 1);
  localparam logic [CW-1:0] OFF_LIM = CW'(OFF_DLY - 1);
  localparam logic [CW-1:0] ON_LIM  = CW'(ON_DLY - 1);
  localparam logic [CW-1:0] BL_LIM  = CW'(BLANK_CYC);

  hb_state_e     st, nst;
  logic [CW-1:0] cnt, ncnt;

  always_comb begin
    nst  = st;
    ncnt = cnt;
    if (!sup_ok_i || tri_trip_i) begin
      nst  = ST_OFF;
      ncnt = '0;
    end else begin
      unique case (st)
        ST_OFF: begin
          ncnt = '0;
          if (hi_q_i)      nst = ST_HS_DT;
          else if (lo_q_i) nst = ST_LS_DT;
        end
        ST_HS_DT: begin
          if (lo_q_i) begin
            nst = ST_LS_DT; ncnt = '0;
          end else if (ls_fb_low_i) begin
            if (cnt == ON_LIM) begin nst = ST_HS_ON; ncnt = '0; end
            else ncnt = cnt + 1'b1;
          end else ncnt = '0;
        end
        ST_HS_ON: if (lo_q_i) begin nst = ST_HS_TOFF; ncnt = '0; end
        ST_HS_TOFF: begin
          if (cnt == OFF_LIM) begin nst = ST_LS_DT; ncnt = '0; end
          else ncnt = cnt + 1'b1;
        end
        ST_LS_DT: begin
          if (hi_q_i) begin
            nst = ST_HS_DT; ncnt = '0;
          end else if (hs_fb_low_i) begin
            if (cnt == ON_LIM) begin nst = ST_LS_ON; ncnt = '0; end
            else ncnt = cnt + 1'b1;
          end else ncnt = '0;
        end
        ST_LS_ON: begin
          if (hi_q_i) begin
            nst = ST_LS_TOFF; ncnt = '0;
          end else if (dem_on_i && zc_i && cnt == BL_LIM) begin
            nst = ST_LS_REL; ncnt = '0;
          end else if (cnt != BL_LIM) ncnt = cnt + 1'b1;
        end
        ST_LS_TOFF: begin
          if (cnt == OFF_LIM) begin nst = ST_HS_DT; ncnt = '0; end
          else ncnt = cnt + 1'b1;
        end
        ST_LS_REL: if (hi_q_i) begin nst = ST_HS_DT; ncnt = '0; end
        default: begin nst = ST_OFF; ncnt = '0; end
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st  <= ST_OFF;
      cnt <= '0;
    end else begin
      st  <= nst;
      cnt <= ncnt;
    end
  end

  // synchronized supply flag clamps both enables in the cycle it drops
  assign hs_on_o = sup_ok_i && (st == ST_HS_ON || st == ST_HS_TOFF);
  assign ls_on_o = sup_ok_i && (st == ST_LS_ON || st == ST_LS_TOFF);
  assign st_o    = st;
endmodule

// File: rtl/hb_gate_seq.sv
module hb_gate_seq
  import hb_gate_pkg::*;
#(
  parameter int unsigned OFF_DLY    = 2,
  parameter int unsigned ON_DLY     = 1,
  parameter int unsigned TSHO_CYC   = 8,
  parameter int unsigned BLANK_CYC  = 8,
  parameter int unsigned MIN_ON_CYC = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] pwm_lvl_i,
  input  logic       dem_en_ni,
  input  logic       zc_i,
  input  logic       hs_gate_low_i,
  input  logic       ls_gate_low_i,
  input  logic       supply_ok_i,
  output logic       hs_on_o,
  output logic       ls_on_o,
  output logic [2:0] state_o
);
  localparam int unsigned NS = 7;

  logic [NS-1:0] raw, syn;
  logic [1:0]    lvl_s;
  logic          dem_n_s, zc_s, hs_fb_s, ls_fb_s, sup_s;
  logic          hi_q, lo_q, tri_trip;
  hb_state_e     st;

  assign raw = {pwm_lvl_i, dem_en_ni, zc_i, hs_gate_low_i, ls_gate_low_i, supply_ok_i};

  hb_sync #(.W(NS), .RST_VAL(7'b0010000)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(raw), .q_o(syn)
  );

  assign {lvl_s, dem_n_s, zc_s, hs_fb_s, ls_fb_s, sup_s} = syn;

  hb_lvl_qual #(.MIN_ON_CYC(MIN_ON_CYC), .TSHO_CYC(TSHO_CYC)) u_qual (
    .clk_i(clk_i), .rst_ni(rst_ni), .lvl_i(lvl_s),
    .hi_q_o(hi_q), .lo_q_o(lo_q), .tri_trip_o(tri_trip)
  );

  hb_fsm #(.OFF_DLY(OFF_DLY), .ON_DLY(ON_DLY), .BLANK_CYC(BLANK_CYC)) u_fsm (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .hi_q_i(hi_q), .lo_q_i(lo_q), .tri_trip_i(tri_trip),
    .sup_ok_i(sup_s), .dem_on_i(!dem_n_s), .zc_i(zc_s),
    .hs_fb_low_i(hs_fb_s), .ls_fb_low_i(ls_fb_s),
    .st_o(st), .hs_on_o(hs_on_o), .ls_on_o(ls_on_o)
  );

  assign state_o = st;
endmodule

// File: rtl/hb_gate_seq_chk.sv
module hb_gate_seq_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       hs_on_o,
  input logic       ls_on_o,
  input logic [2:0] state_o,
  input logic       sup_s,
  input logic       hs_fb_s,
  input logic       ls_fb_s,
  input logic       tri_trip,
  input logic       hi_q
);
  // R3
  hs_after_ls_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(hs_on_o) |-> ($past(ls_fb_s) && !$past(ls_on_o)));
  // R3
  ls_after_hs_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ls_on_o) |-> ($past(hs_fb_s) && !$past(hs_on_o)));
  // R11
  supply_clamp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sup_s |=> (state_o == 3'd0));
  // R6
  tri_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tri_trip |=> (!hs_on_o && !ls_on_o));
  // R4
  hs_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(hs_on_o) |-> (!sup_s || $past(tri_trip) || $past(state_o) == 3'd3));
  // R10
  rel_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 3'd7 && !hi_q && sup_s && !tri_trip) |=> (state_o == 3'd7));
endmodule

bind hb_gate_seq hb_gate_seq_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .hs_on_o(hs_on_o), .ls_on_o(ls_on_o),
  .state_o(state_o), .sup_s(sup_s), .hs_fb_s(hs_fb_s), .ls_fb_s(ls_fb_s),
  .tri_trip(tri_trip), .hi_q(hi_q)
);

// File: tb/sim_hb_gate_seq.sv
`timescale 1ns/1ps
module sim_hb_gate_seq;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic [1:0] lvl = 2'b00;
  logic dem_n = 1'b1, zc = 1'b0, sup = 1'b0, ls_stuck = 1'b0;
  logic hs_on, ls_on;
  logic [2:0] st;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  hb_gate_seq u0 (
    .clk_i(clk), .rst_ni(rst_ni), .pwm_lvl_i(lvl), .dem_en_ni(dem_n), .zc_i(zc),
    .hs_gate_low_i(!hs_on), .ls_gate_low_i(ls_stuck ? 1'b0 : !ls_on),
    .supply_ok_i(sup), .hs_on_o(hs_on), .ls_on_o(ls_on), .state_o(st)
  );

  // {lvl, dem_n, zc, sup, wait, hs, ls, state}
  localparam int NV = 15;
  localparam logic [17:0] VEC [NV] = '{
    {2'b00, 1'b1, 1'b0, 1'b1, 8'd10, 1'b0, 1'b1, 3'd5}, // R2 low
    {2'b01, 1'b1, 1'b0, 1'b1, 8'd12, 1'b1, 1'b0, 3'd2}, // R2 high
    {2'b00, 1'b1, 1'b1, 1'b1, 8'd12, 1'b0, 1'b1, 3'd5}, // R8 zc ignored
    {2'b10, 1'b1, 1'b0, 1'b1, 8'd4,  1'b0, 1'b1, 3'd5}, // R6 short mid
    {2'b10, 1'b1, 1'b0, 1'b1, 8'd12, 1'b0, 1'b0, 3'd0}, // R6 hold-off
    {2'b01, 1'b1, 1'b0, 1'b1, 8'd12, 1'b1, 1'b0, 3'd2}, // R7 resume
    {2'b11, 1'b1, 1'b0, 1'b1, 8'd14, 1'b0, 1'b0, 3'd0}, // R6 code 11
    {2'b00, 1'b0, 1'b0, 1'b1, 8'd12, 1'b0, 1'b1, 3'd5}, // R9 no zc yet
    {2'b00, 1'b0, 1'b1, 1'b1, 8'd14, 1'b0, 1'b0, 3'd7}, // R9 release
    {2'b00, 1'b0, 1'b0, 1'b1, 8'd10, 1'b0, 1'b0, 3'd7}, // R10 stay off
    {2'b01, 1'b0, 1'b0, 1'b1, 8'd12, 1'b1, 1'b0, 3'd2}, // R10 next high
    {2'b00, 1'b0, 1'b0, 1'b1, 8'd12, 1'b0, 1'b1, 3'd5}, // R10 low again
    {2'b10, 1'b0, 1'b0, 1'b1, 8'd14, 1'b0, 1'b0, 3'd0}, // R12 tri in DEM
    {2'b00, 1'b1, 1'b0, 1'b0, 8'd6,  1'b0, 1'b0, 3'd0}, // R11 supply low
    {2'b00, 1'b1, 1'b0, 1'b1, 8'd10, 1'b0, 1'b1, 3'd5}  // R7 supply back
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk3(input string req, input int h, input int l, input int s);
    chk({req, " hs"}, int'(hs_on), h);
    chk({req, " ls"}, int'(ls_on), l);
    chk({req, " state"}, int'(st), s);
  endtask

  initial begin
    #2000000;
    if (!done) begin
      errors++;
      $display("FAIL R1 watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    cyc(3);
    chk3("R1 in reset", 0, 0, 0);
    rst_ni = 1'b1;
    cyc(6);
    chk3("R1 supply low", 0, 0, 0);
    sup = 1'b1;

    for (int i = 0; i < NV; i++) begin
      {lvl, dem_n, zc, sup} = VEC[i][17:13];
      cyc(int'(VEC[i][12:5]));
      chk3($sformatf("vec%0d", i), int'(VEC[i][4]), int'(VEC[i][3]), int'(VEC[i][2:0]));
    end

    // R5: one-cycle high rejected
    lvl = 2'b01; cyc(1); lvl = 2'b00; cyc(10);
    chk3("R5 short high", 0, 1, 5);
    // R5: two-cycle high accepted
    begin
      bit seen_off = 1'b0;
      lvl = 2'b01; cyc(2); lvl = 2'b00;
      for (int k = 0; k < 12; k++) begin
        cyc(1);
        if (!ls_on) seen_off = 1'b1;
      end
      chk("R5 accepted high", int'(seen_off), 1);
      cyc(8);
      chk3("R5 back low", 0, 1, 5);
    end

    // R3: stuck low-side feedback blocks high side
    ls_stuck = 1'b1; lvl = 2'b01; cyc(15);
    chk3("R3 stuck fb", 0, 0, 1);
    ls_stuck = 1'b0; cyc(8);
    chk3("R3 fb released", 1, 0, 2);

    // R4: exact turn-off delay
    lvl = 2'b00; cyc(4);
    chk3("R4 hold", 1, 0, 3);
    cyc(1);
    chk("R4 off hs", int'(hs_on), 0);

    // R9: zc inside blanking ignored
    lvl = 2'b01; cyc(12);
    dem_n = 1'b0; lvl = 2'b00;
    for (int k = 0; k < 20 && !ls_on; k++) cyc(1);
    zc = 1'b1; cyc(2); zc = 1'b0; cyc(15);
    chk3("R9 blanking", 0, 1, 5);
    zc = 1'b1; cyc(14);
    chk3("R9 after blank", 0, 0, 7);
    zc = 1'b0;

    // R11: clamp two edges after supply fall
    lvl = 2'b01; cyc(12);
    chk("R11 pre hs", int'(hs_on), 1);
    sup = 1'b0; cyc(2);
    chk("R11 clamp hs", int'(hs_on), 0);
    chk("R11 clamp ls", int'(ls_on), 0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule